// File: doc/BRIEF.md
# Raster-Op Operand Permutation Translator

This block takes a native 8-bit raster-operation byte and a 5-bit operand-routing configuration, and produces a standard ternary ROP code. The configuration is held in bits 28:24 of a 32-bit object context word. The translated code is then applied bit by bit to three 32-bit operand words (pattern, source and destination). The result word and the translated code are registered together. An output strobe marks each result.

Most configurations reorder the operand positions of the ROP truth table before it is evaluated. Two configurations instead build the code from replicated bit groups. One configuration forces a plain source copy. The values that are left over are illegal: they give a zero code and raise a flag.

The block is a single pipeline stage. A new operation may be presented on every clock, and the result for an operation presented at one edge is visible after the next edge.

Top module: `ropPermuteUnit`

## Requirements
- R1: The configuration is bits 28:24 of `ctxWord`. No other context bit changes any output.
- R2: Configuration 0x17 always yields code 0xCC, whatever `nativeRop` holds. This rule wins over every other rule.
- R3: For configurations 0x01 to 0x07, the selector for position k (k = 0, 1, 2) is bit k of the configuration.
- R4: For configurations 0x08 to 0x0E, the selector for position k is bit k of the configuration plus one.
- R5: Configurations 0x10 to 0x15 use fixed selector triples (position 0, 1, 2): 0x10=(0,1,2), 0x11=(1,0,2), 0x12=(0,2,1), 0x13=(2,0,1), 0x14=(1,2,0), 0x15=(2,1,0).
- R6: For the selector cases (R3, R4, R5), code bit i (0..7) is formed as follows:
  - s0 is bit (selector 0) of i, s1 is bit (selector 1) of i, and s2 is bit (selector 2) of i.
  - Code bit i equals `nativeRop` bit (4·s2 + 2·s1 + s0).
- R7: For configuration 0x00, the code is the OR of these groups:
  - 0x11 if ROP bit 0 is set;
  - 0x44 if any ROP bit under mask 0x16 is set;
  - 0x22 if any ROP bit under mask 0x68 is set;
  - 0x88 if ROP bit 7 is set.
- R8: For configuration 0x0F, the groups are the same, but they map to 0x03, 0x0C, 0x30 and 0xC0 in that order.
- R9: Configurations 0x16 and 0x18 to 0x1F are illegal. They give code 0x00, and `cfgInvalid` is high in the cycle that carries that result.
- R10: Result bit j equals code bit (4·`patWord`[j] + 2·`srcWord`[j] + `dstWord`[j]).
- R11: `outValid` is `inValid` delayed by one clock. `cfgInvalid` is low whenever `outValid` is low. `ropCode` and `resultWord` hold their values when no operation is presented.
- R12: Synchronous reset clears `outValid`, `cfgInvalid`, `ropCode` and `resultWord`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation presented this cycle |
| ctxWord | input | 32 | Object context word; the configuration is bits 28:24 |
| nativeRop | input | 8 | Native raster-operation byte |
| srcWord | input | 32 | Source operand |
| dstWord | input | 32 | Destination operand |
| patWord | input | 32 | Pattern operand |
| outValid | output | 1 | Registered result valid |
| ropCode | output | 8 | Registered translated ternary code |
| resultWord | output | 32 | Registered result of the ternary evaluation |
| cfgInvalid | output | 1 | Illegal configuration flag for the current result |

## Verification
The bench sweeps all 32 configurations against all 256 ROP bytes. This catches a swizzle decoder with selectors off by one in the 0x08 to 0x0E range, which would return the bits of the neighbouring configuration. It also catches swapped entries in the fixed triples, which would transpose truth-table halves. It checks that the bypass code wins even for ROP bytes whose other rules would give a different code; a design with the wrong priority would give a permuted code instead of 0xCC. Bubble cycles and a mid-stream reset check the hold, flag-clear and reset rules. Scrambled non-field context bits check that an over-wide field decode would show up as a wrong code.

// File: rtl/ropxlat_pkg.sv
package ropxlat_pkg;

  // Three operands per ternary lookup: pattern, source, destination.
  localparam int ROP_OPS = 3;
  localparam int ROP_W   = 1 << ROP_OPS;

  typedef enum logic [2:0] {
    XL_BYPASS  = 3'd0,
    XL_GROUPLO = 3'd1,
    XL_GROUPHI = 3'd2,
    XL_SWIZZLE = 3'd3,
    XL_BAD     = 3'd4
  } xlatMode_e;

  // Strobes handed from the decoder to the datapath.
  typedef struct packed {
    logic      capture;
    logic      markBad;
    xlatMode_e mode;
    logic [1:0] sel0;
    logic [1:0] sel1;
    logic [1:0] sel2;
  } xlatStrobes_t;

  localparam logic [ROP_W-1:0] SRC_COPY_CODE = 8'hCC;

endpackage

// File: rtl/ropCtrl.sv
module ropCtrl
  import ropxlat_pkg::*;
#(
  parameter int CFG_W = 5
) (
  input  logic             inValid,
  input  logic [CFG_W-1:0] cfg,
  output xlatStrobes_t     strb
);

  localparam logic [CFG_W-1:0] CFG_BYPASS  = CFG_W'(8'h17);
  localparam logic [CFG_W-1:0] CFG_GRP_LO  = CFG_W'(8'h00);
  localparam logic [CFG_W-1:0] CFG_GRP_HI  = CFG_W'(8'h0F);
  localparam logic [CFG_W-1:0] CFG_LOWTOP  = CFG_W'(8'h08);
  localparam logic [CFG_W-1:0] CFG_FIXBASE = CFG_W'(8'h10);
  localparam logic [CFG_W-1:0] CFG_FIXTOP  = CFG_W'(8'h15);

  always_comb begin
    strb         = '0;
    strb.capture = inValid;
    strb.mode    = XL_BAD;
    // The bypass test comes first so that it overrides every other rule (R2).
    if (cfg == CFG_BYPASS) begin
      strb.mode = XL_BYPASS;
    end else if (cfg == CFG_GRP_LO) begin
      strb.mode = XL_GROUPLO;
    end else if (cfg == CFG_GRP_HI) begin
      strb.mode = XL_GROUPHI;
    end else if (cfg < CFG_LOWTOP) begin
      // R3: the selector is the raw configuration bit.
      strb.mode = XL_SWIZZLE;
      strb.sel0 = {1'b0, cfg[0]};
      strb.sel1 = {1'b0, cfg[1]};
      strb.sel2 = {1'b0, cfg[2]};
    end else if (cfg < CFG_GRP_HI) begin
      // R4: the selector is the configuration bit plus one (gives 1 or 2).
      strb.mode = XL_SWIZZLE;
      strb.sel0 = {cfg[0], ~cfg[0]};
      strb.sel1 = {cfg[1], ~cfg[1]};
      strb.sel2 = {cfg[2], ~cfg[2]};
    end else if (cfg >= CFG_FIXBASE && cfg <= CFG_FIXTOP) begin
      // R5: fixed triples.
      strb.mode = XL_SWIZZLE;
      case (cfg[2:0])
        3'd0:    begin strb.sel0 = 2'd0; strb.sel1 = 2'd1; strb.sel2 = 2'd2; end
        3'd1:    begin strb.sel0 = 2'd1; strb.sel1 = 2'd0; strb.sel2 = 2'd2; end
        3'd2:    begin strb.sel0 = 2'd0; strb.sel1 = 2'd2; strb.sel2 = 2'd1; end
        3'd3:    begin strb.sel0 = 2'd2; strb.sel1 = 2'd0; strb.sel2 = 2'd1; end
        3'd4:    begin strb.sel0 = 2'd1; strb.sel1 = 2'd2; strb.sel2 = 2'd0; end
        default: begin strb.sel0 = 2'd2; strb.sel1 = 2'd1; strb.sel2 = 2'd0; end
      endcase
    end
    strb.markBad = inValid && (strb.mode == XL_BAD);
  end

endmodule

// File: rtl/ropDatapath.sv
module ropDatapath
  import ropxlat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  xlatStrobes_t      strb,
  input  logic [ROP_W-1:0]  nativeRop,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [DATA_W-1:0] dstWord,
  input  logic [DATA_W-1:0] patWord,
  output logic              outValid,
  output logic [ROP_W-1:0]  ropCode,
  output logic [DATA_W-1:0] resultWord,
  output logic              cfgInvalid
);

  function automatic logic pickBit(input logic [ROP_OPS-1:0] v, input logic [1:0] s);
    case (s)
      2'd0:    pickBit = v[0];
      2'd1:    pickBit = v[1];
      default: pickBit = v[2];
    endcase
  endfunction

  logic [ROP_W-1:0]  permCode;
  logic [ROP_W-1:0]  groupLo;
  logic [ROP_W-1:0]  groupHi;
  logic [ROP_W-1:0]  codeNext;
  logic [DATA_W-1:0] resNext;
  logic g0, g1, g2, g3;

  // Per-bit operand reordering of the truth table (R6).
  for (genvar i = 0; i < ROP_W; i++) begin : g_perm
    localparam logic [ROP_OPS-1:0] POS = ROP_OPS'(i);
    assign permCode[i] = nativeRop[{pickBit(POS, strb.sel2),
                                    pickBit(POS, strb.sel1),
                                    pickBit(POS, strb.sel0)}];
  end

  // Group replication for the two special configurations (R7, R8).
  assign g0 = nativeRop[0];
  assign g1 = |(nativeRop & 8'h16);
  assign g2 = |(nativeRop & 8'h68);
  assign g3 = nativeRop[7];
  assign groupLo = {g3, g1, g2, g0, g3, g1, g2, g0};
  assign groupHi = {g3, g3, g2, g2, g1, g1, g0, g0};

  always_comb begin
    case (strb.mode)
      XL_BYPASS:  codeNext = SRC_COPY_CODE;
      XL_GROUPLO: codeNext = groupLo;
      XL_GROUPHI: codeNext = groupHi;
      XL_SWIZZLE: codeNext = permCode;
      default:    codeNext = '0;
    endcase
  end

  // Bitwise ternary evaluation (R10).
  for (genvar j = 0; j < DATA_W; j++) begin : g_eval
    assign resNext[j] = codeNext[{patWord[j], srcWord[j], dstWord[j]}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      cfgInvalid <= 1'b0;
      ropCode    <= '0;
      resultWord <= '0;
    end else begin
      outValid   <= strb.capture;
      cfgInvalid <= strb.markBad;
      if (strb.capture) begin
        ropCode    <= codeNext;
        resultWord <= resNext;
      end
    end
  end

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    strb.capture |=> outValid);
  a_r11_idle_drops: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> !outValid);
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> ($stable(ropCode) && $stable(resultWord)));
  a_r9_flag_with_valid: assert property (@(posedge clk) disable iff (rst)
    cfgInvalid |-> outValid);
  a_r9_bad_code_zero: assert property (@(posedge clk) disable iff (rst)
    cfgInvalid |-> (ropCode == '0));

endmodule

// File: rtl/ropPermuteUnit.sv
module ropPermuteUnit
  import ropxlat_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CTX_W   = 32,
  parameter int CFG_LSB = 24,
  parameter int CFG_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [CTX_W-1:0]  ctxWord,
  input  logic [7:0]        nativeRop,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [DATA_W-1:0] dstWord,
  input  logic [DATA_W-1:0] patWord,
  output logic              outValid,
  output logic [7:0]        ropCode,
  output logic [DATA_W-1:0] resultWord,
  output logic              cfgInvalid
);

  localparam int CFG_MSB = CFG_LSB + CFG_W - 1;
  localparam logic [CTX_W-1:0] CFG_MASK = CTX_W'({CFG_W{1'b1}}) << CFG_LSB;

  logic [CFG_W-1:0] cfg;
  logic             unusedCtxBits;
  xlatStrobes_t     strb;

  assign cfg           = ctxWord[CFG_MSB:CFG_LSB];
  assign unusedCtxBits = ^(ctxWord & ~CFG_MASK);

  ropCtrl #(.CFG_W(CFG_W)) u_ctrl (
    .inValid (inValid),
    .cfg     (cfg),
    .strb    (strb)
  );

  ropDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .nativeRop  (nativeRop),
    .srcWord    (srcWord),
    .dstWord    (dstWord),
    .patWord    (patWord),
    .outValid   (outValid),
    .ropCode    (ropCode),
    .resultWord (resultWord),
    .cfgInvalid (cfgInvalid)
  );

  a_r2_bypass_wins: assert property (@(posedge clk) disable iff (rst)
    (inValid && cfg == CFG_W'(8'h17)) |=> (ropCode == 8'hCC));

endmodule

// File: tb/tb_ropPermuteUnit.sv
`timescale 1ns/1ps
module tb_ropPermuteUnit;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [31:0] ctxWord;
  logic [7:0]  nativeRop;
  logic [31:0] srcWord, dstWord, patWord;
  logic        outValid;
  logic [7:0]  ropCode;
  logic [31:0] resultWord;
  logic        cfgInvalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]  expCode;
  logic [31:0] expRes;
  logic        expValid, expBad;

  always #10 clk = ~clk;

  ropPermuteUnit dut (
    .clk(clk), .rst(rst), .inValid(inValid), .ctxWord(ctxWord),
    .nativeRop(nativeRop), .srcWord(srcWord), .dstWord(dstWord),
    .patWord(patWord), .outValid(outValid), .ropCode(ropCode),
    .resultWord(resultWord), .cfgInvalid(cfgInvalid)
  );

  // Behavioural translation model built from the requirements.
  function automatic logic [7:0] refXlat(input int cfg, input int rop, output bit bad);
    int ix[3];
    bit swz;
    logic [7:0] r;
    bad = 0; swz = 0; r = 8'h00;
    if (cfg == 'h17) return 8'hCC;
    if (cfg == 0 || cfg == 'h0F) begin
      int grp[4];
      grp[0] = rop & 1; grp[1] = (rop & 'h16) != 0;
      grp[2] = (rop & 'h68) != 0; grp[3] = (rop >> 7) & 1;
      if (cfg == 0) begin
        if (grp[0] != 0) r |= 8'h11;
        if (grp[1] != 0) r |= 8'h44;
        if (grp[2] != 0) r |= 8'h22;
        if (grp[3] != 0) r |= 8'h88;
      end else begin
        if (grp[0] != 0) r |= 8'h03;
        if (grp[1] != 0) r |= 8'h0C;
        if (grp[2] != 0) r |= 8'h30;
        if (grp[3] != 0) r |= 8'hC0;
      end
      return r;
    end
    if (cfg < 8) begin
      for (int k = 0; k < 3; k++) ix[k] = (cfg >> k) & 1;
      swz = 1;
    end else if (cfg < 'h0F) begin
      for (int k = 0; k < 3; k++) ix[k] = ((cfg >> k) & 1) + 1;
      swz = 1;
    end else begin
      swz = 1;
      case (cfg)
        'h10: begin ix[0] = 0; ix[1] = 1; ix[2] = 2; end
        'h11: begin ix[0] = 1; ix[1] = 0; ix[2] = 2; end
        'h12: begin ix[0] = 0; ix[1] = 2; ix[2] = 1; end
        'h13: begin ix[0] = 2; ix[1] = 0; ix[2] = 1; end
        'h14: begin ix[0] = 1; ix[1] = 2; ix[2] = 0; end
        'h15: begin ix[0] = 2; ix[1] = 1; ix[2] = 0; end
        default: begin swz = 0; bad = 1; end
      endcase
    end
    if (swz) begin
      for (int i = 0; i < 8; i++) begin
        int s;
        s = ((i >> ix[2]) & 1) * 4 + ((i >> ix[1]) & 1) * 2 + ((i >> ix[0]) & 1);
        r[i] = rop[s];
      end
    end
    return r;
  endfunction

  function automatic string tagFor(input int cfg);
    if (cfg == 'h17) return "R2";
    if (cfg == 0) return "R7";
    if (cfg == 'h0F) return "R8";
    if (cfg < 8) return "R3/R6";
    if (cfg < 'h0F) return "R4/R6";
    if (cfg >= 'h10 && cfg <= 'h15) return "R5/R6";
    return "R9";
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic printSummary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Drive one cycle at a negative edge, then compare at the next negative edge.
  task automatic step(input bit v, input logic [31:0] ctx, input logic [7:0] rop,
                      input logic [31:0] s, input logic [31:0] d, input logic [31:0] p,
                      input string tagOverride);
    int cfg;
    bit bad;
    logic [7:0] code;
    string tag;
    cfg = int'(ctx[28:24]);
    inValid = v; ctxWord = ctx; nativeRop = rop;
    srcWord = s; dstWord = d; patWord = p;
    tag = (tagOverride.len() != 0) ? tagOverride : tagFor(cfg);
    if (v) begin
      code = refXlat(cfg, int'(rop), bad);
      expCode = code;
      for (int j = 0; j < 32; j++) expRes[j] = code[{p[j], s[j], d[j]}];
      expValid = 1'b1;
      expBad = bad;
    end else begin
      expValid = 1'b0;
      expBad = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R11", "outValid", 32'(outValid), 32'(expValid));
    chk(v ? "R9" : "R11", "cfgInvalid", 32'(cfgInvalid), 32'(expBad));
    chk(v ? tag : "R11", "ropCode", 32'(ropCode), 32'(expCode));
    chk(v ? "R10" : "R11", "resultWord", resultWord, expRes);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      printSummary();
      $finish;
    end
  end

  initial begin
    logic [31:0] ctx;
    rst = 1'b1; inValid = 1'b0; ctxWord = '0; nativeRop = '0;
    srcWord = '0; dstWord = '0; patWord = '0;
    expCode = '0; expRes = '0; expValid = 1'b0; expBad = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk("R12", "outValid", 32'(outValid), 32'd0);
    chk("R12", "cfgInvalid", 32'(cfgInvalid), 32'd0);
    chk("R12", "ropCode", 32'(ropCode), 32'd0);
    chk("R12", "resultWord", resultWord, 32'd0);
    rst = 1'b0;

    // Exhaustive sweep: every configuration with every ROP byte,
    // alternating a full-coverage operand pattern with random operands.
    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int rop = 0; rop < 256; rop++) begin
        ctx = {3'b000, 5'(cfg), 24'h000000};
        if (rop[0])
          step(1'b1, ctx, 8'(rop), $urandom, $urandom, $urandom, "");
        else
          step(1'b1, ctx, 8'(rop), 32'hFF00FF00, 32'hF0F0F0F0, 32'hFFFF0000, "");
        if (rop % 37 == 5)
          step(1'b0, $urandom, $urandom, $urandom, $urandom, $urandom, "R11");
      end
    end

    // R1: scrambled bits outside 28:24 must not matter.
    for (int n = 0; n < 300; n++) begin
      ctx = $urandom;
      step(1'b1, ctx, 8'($urandom), $urandom, $urandom, $urandom, "R1");
    end

    // R2: bypass beats ROP bytes that would otherwise give a different code.
    step(1'b1, 32'h17000000, 8'h00, 32'h12345678, 32'h9ABCDEF0, 32'h0F0F0F0F, "R2");
    step(1'b1, 32'hF7FFFFFF, 8'hFF, 32'hCAFEF00D, 32'h0, 32'hFFFFFFFF, "R2");

    // R9 then a legal operation: the flag must drop.
    step(1'b1, 32'h16000000, 8'hA5, $urandom, $urandom, $urandom, "R9");
    step(1'b1, 32'h1F000000, 8'h5A, $urandom, $urandom, $urandom, "R9");
    step(1'b1, 32'h10000000, 8'hCA, 32'hAAAA5555, 32'h33333333, 32'h0F0F0F0F, "R5");

    // R12: reset in mid-stream clears the outputs.
    step(1'b1, 32'h14000000, 8'h96, $urandom, $urandom, $urandom, "R5");
    rst = 1'b1;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    chk("R12", "outValid", 32'(outValid), 32'd0);
    chk("R12", "cfgInvalid", 32'(cfgInvalid), 32'd0);
    chk("R12", "ropCode", 32'(ropCode), 32'd0);
    chk("R12", "resultWord", resultWord, 32'd0);
    expCode = '0;
    expRes = '0;
    step(1'b0, 32'h16000000, 8'hFF, $urandom, $urandom, $urandom, "R11");

    done = 1;
    printSummary();
    $finish;
  end

endmodule